// File: doc/BRIEF.md
# Clock Root Configuration Update Controller

This block is the register-programmed control point of one clock root. Software writes the source select, the divider, the mode and the fractional M, N and D values into shadow registers. Those writes change nothing at the clock outputs. A separate update request in the command register asks for the shadow values to become active. The active set is then loaded at a point the clock-side logic marks as safe. That point is signalled by a one-cycle `applyAck` pulse. If the pulse never arrives, a bounded timeout forces the load, so a polling loop of limited length always sees the update finish.

The command register carries the update request, which clears by itself. It also holds a root-enable request and one dirty flag per shadow register. A read-only root-off status bit, refreshed at each safe point, shows whether the root is running. Reads of the shadow registers return the shadow values and never the active ones. The source multiplexer and the divider datapath sit outside this block. It only drives their active configuration.

Top module: `clk_root_cfg`

## Requirements
- R1: After reset the command register (address 0) reads 0x8000_0000: root-off bit 31 set, all other bits clear. The configuration (address 1), M (address 2), N (address 3) and D (address 4) registers read 0. Every active output and `rootEn` are 0.
- R2: A write to the configuration, M, N or D register changes its readback at once. The active outputs stay unchanged until a load.
- R3: A write to a shadow register sets its dirty flag in the command register: configuration sets bit 4, N sets bit 5, M sets bit 6 and D sets bit 7.
- R4: Writing 1 to command bit 0 sets the update request, which reads back as 1 until the load. Writing 0 to bit 0 does not cancel a pending request.
- R5: While an update is pending, an `applyAck` pulse loads all active outputs from the shadow registers at that clock edge. The same edge clears bit 0 and all dirty flags.
- R6: An `applyAck` pulse with no update pending leaves the active outputs and the dirty flags unchanged.
- R7: If no `applyAck` arrives, the load is forced TIMEOUT_CYC cycles after the request is accepted. Bit 0 still reads 1 one cycle before that.
- R8: The configuration word holds the divider in bits DIV_W-1:0, the source select in bits 10:8 and the mode in bits 13:12. All other bits read 0. `dualEdge` is 1 when the active mode is 2.
- R9: Command bit 1 drives `rootEn` from the next cycle on. Bit 31 (root-off) takes the inverse of that request at each `applyAck` pulse and holds otherwise.
- R10: Writes to command bit 31 and to command bits 7:4 are ignored.
- R11: A shadow write in the same cycle as a load does not reach the active outputs. Its dirty flag remains set after the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 3 | Register address, 0 to 4 |
| busWrEn | input | 1 | Write strobe, one write per cycle |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr, combinational |
| applyAck | input | 1 | One-cycle safe-point pulse from the clock side |
| srcSel | output | 3 | Active source select |
| divVal | output | DIV_W | Active divider value |
| modeVal | output | 2 | Active mode |
| dualEdge | output | 1 | Active mode is dual-edge (value 2) |
| mVal | output | MND_W | Active M value |
| nVal | output | MND_W | Active N value |
| dVal | output | MND_W | Active D value |
| rootEn | output | 1 | Root-enable request |

## Verification
The hardest situation to reach from the ports is a shadow write that lands in exactly the cycle of the load. The bench keeps an update pending. On a single negative edge it then drives a configuration write and the `applyAck` pulse together. After the next edge it checks that the outputs hold the older shadow value while the new value and its dirty flag remain. The forced load is hit by withholding `applyAck` and sampling the update bit one cycle before and one cycle after the timeout.

// File: rtl/crc_pkg.sv
package crc_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_CMD = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_CFG = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_M   = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_N   = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_D   = 3'd4;

  localparam int CMD_UPD_BIT  = 0;
  localparam int CMD_EN_BIT   = 1;
  localparam int CMD_DIRTY_LO = 4;
  localparam int CMD_OFF_BIT  = 31;

  localparam int SRC_LO  = 8;
  localparam int MODE_LO = 12;
  localparam logic [1:0] MODE_DUAL = 2'd2;

  // dirty flag order follows command bits 4..7
  localparam int DIRTY_CFG = 0;
  localparam int DIRTY_N   = 1;
  localparam int DIRTY_M   = 2;
  localparam int DIRTY_D   = 3;

  typedef struct packed {
    logic wrCfg;
    logic wrM;
    logic wrN;
    logic wrD;
    logic loadActive;
  } crcStrobe_t;
endpackage

// File: rtl/crc_ctrl.sv
module crc_ctrl
  import crc_pkg::*;
#(
  parameter int TIMEOUT_CYC = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [1:0]        cmdWrBits,
  input  logic              applyAck,
  output crcStrobe_t        strb,
  output logic [31:0]       cmdView,
  output logic              rootEn
);
  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYC - 1);

  logic             updPending;
  logic             rootEnReq;
  logic             rootOff;
  logic [3:0]       dirty;
  logic [3:0]       dirtyNext;
  logic [3:0]       shadowWr;
  logic [CNT_W-1:0] waitCnt;
  logic             cmdWr;
  logic             timedOut;

  always_comb begin
    cmdWr           = busWrEn && (busAddr == ADDR_CMD);
    strb.wrCfg      = busWrEn && (busAddr == ADDR_CFG);
    strb.wrM        = busWrEn && (busAddr == ADDR_M);
    strb.wrN        = busWrEn && (busAddr == ADDR_N);
    strb.wrD        = busWrEn && (busAddr == ADDR_D);
    timedOut        = updPending && (waitCnt == CNT_LAST);
    strb.loadActive = updPending && (applyAck || timedOut);
  end

  always_comb begin
    shadowWr            = '0;
    shadowWr[DIRTY_CFG] = strb.wrCfg;
    shadowWr[DIRTY_N]   = strb.wrN;
    shadowWr[DIRTY_M]   = strb.wrM;
    shadowWr[DIRTY_D]   = strb.wrD;
    for (int i = 0; i < 4; i++) begin
      if (shadowWr[i])           dirtyNext[i] = 1'b1;
      else if (strb.loadActive)  dirtyNext[i] = 1'b0;
      else                       dirtyNext[i] = dirty[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      updPending <= 1'b0;
      rootEnReq  <= 1'b0;
      rootOff    <= 1'b1;
      dirty      <= '0;
      waitCnt    <= '0;
    end else begin
      dirty <= dirtyNext;
      if (cmdWr && cmdWrBits[CMD_UPD_BIT]) updPending <= 1'b1;
      else if (strb.loadActive)            updPending <= 1'b0;
      if (cmdWr) rootEnReq <= cmdWrBits[CMD_EN_BIT];
      if (applyAck) rootOff <= !rootEnReq;
      if (!updPending || strb.loadActive) waitCnt <= '0;
      else                                waitCnt <= waitCnt + 1'b1;
    end
  end

  always_comb begin
    cmdView                                 = '0;
    cmdView[CMD_UPD_BIT]                    = updPending;
    cmdView[CMD_EN_BIT]                     = rootEnReq;
    cmdView[CMD_DIRTY_LO+3:CMD_DIRTY_LO]    = dirty;
    cmdView[CMD_OFF_BIT]                    = rootOff;
  end

  assign rootEn = rootEnReq;

  // R4
  pending_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    updPending && !applyAck && (waitCnt != CNT_LAST) |=> updPending);

  // R7
  wait_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    updPending |-> (waitCnt < CNT_W'(TIMEOUT_CYC)));

  // R9
  root_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !applyAck |=> $stable(rootOff));

  // R5
  dirty_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadActive && !busWrEn |=> (dirty == 4'd0) && !updPending);
endmodule

// File: rtl/crc_datapath.sv
module crc_datapath
  import crc_pkg::*;
#(
  parameter int DIV_W = 5,
  parameter int MND_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  crcStrobe_t        strb,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DIV_W-1:0]  wrDiv,
  input  logic [2:0]        wrSrc,
  input  logic [1:0]        wrMode,
  input  logic [MND_W-1:0]  wrMnd,
  input  logic [31:0]       cmdView,
  output logic [31:0]       busRdData,
  output logic [2:0]        srcSel,
  output logic [DIV_W-1:0]  divVal,
  output logic [1:0]        modeVal,
  output logic              dualEdge,
  output logic [MND_W-1:0]  mVal,
  output logic [MND_W-1:0]  nVal,
  output logic [MND_W-1:0]  dVal
);
  logic [DIV_W-1:0] shDiv;
  logic [2:0]       shSrc;
  logic [1:0]       shMode;
  logic [MND_W-1:0] shM, shN, shD;
  logic [31:0]      cfgWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shDiv <= '0; shSrc <= '0; shMode <= '0;
      shM <= '0; shN <= '0; shD <= '0;
    end else begin
      if (strb.wrCfg) begin
        shDiv  <= wrDiv;
        shSrc  <= wrSrc;
        shMode <= wrMode;
      end
      if (strb.wrM) shM <= wrMnd;
      if (strb.wrN) shN <= wrMnd;
      if (strb.wrD) shD <= wrMnd;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divVal <= '0; srcSel <= '0; modeVal <= '0;
      mVal <= '0; nVal <= '0; dVal <= '0;
    end else if (strb.loadActive) begin
      divVal  <= shDiv;
      srcSel  <= shSrc;
      modeVal <= shMode;
      mVal    <= shM;
      nVal    <= shN;
      dVal    <= shD;
    end
  end

  assign dualEdge = (modeVal == MODE_DUAL);

  always_comb begin
    cfgWord                      = '0;
    cfgWord[DIV_W-1:0]           = shDiv;
    cfgWord[SRC_LO+2:SRC_LO]     = shSrc;
    cfgWord[MODE_LO+1:MODE_LO]   = shMode;
    case (busAddr)
      ADDR_CMD: busRdData = cmdView;
      ADDR_CFG: busRdData = cfgWord;
      ADDR_M:   busRdData = 32'(shM);
      ADDR_N:   busRdData = 32'(shN);
      ADDR_D:   busRdData = 32'(shD);
      default:  busRdData = '0;
    endcase
  end

  // R2
  active_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadActive |=> $stable({divVal, srcSel, modeVal, mVal, nVal, dVal}));

  // R5
  load_copy_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadActive |=> (divVal == $past(shDiv)) && (srcSel == $past(shSrc))
                     && (modeVal == $past(shMode)) && (mVal == $past(shM))
                     && (nVal == $past(shN)) && (dVal == $past(shD)));
endmodule

// File: rtl/clk_root_cfg.sv
module clk_root_cfg
  import crc_pkg::*;
#(
  parameter int DIV_W       = 5,
  parameter int MND_W       = 8,
  parameter int TIMEOUT_CYC = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        busAddr,
  input  logic              busWrEn,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData,
  input  logic              applyAck,
  output logic [2:0]        srcSel,
  output logic [DIV_W-1:0]  divVal,
  output logic [1:0]        modeVal,
  output logic              dualEdge,
  output logic [MND_W-1:0]  mVal,
  output logic [MND_W-1:0]  nVal,
  output logic [MND_W-1:0]  dVal,
  output logic              rootEn
);
  crcStrobe_t  strb;
  logic [31:0] cmdView;

  crc_ctrl #(.TIMEOUT_CYC(TIMEOUT_CYC)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .busAddr   (busAddr),
    .busWrEn   (busWrEn),
    .cmdWrBits (busWrData[1:0]),
    .applyAck  (applyAck),
    .strb      (strb),
    .cmdView   (cmdView),
    .rootEn    (rootEn)
  );

  crc_datapath #(.DIV_W(DIV_W), .MND_W(MND_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .busAddr   (busAddr),
    .wrDiv     (busWrData[DIV_W-1:0]),
    .wrSrc     (busWrData[SRC_LO+2:SRC_LO]),
    .wrMode    (busWrData[MODE_LO+1:MODE_LO]),
    .wrMnd     (busWrData[MND_W-1:0]),
    .cmdView   (cmdView),
    .busRdData (busRdData),
    .srcSel    (srcSel),
    .divVal    (divVal),
    .modeVal   (modeVal),
    .dualEdge  (dualEdge),
    .mVal      (mVal),
    .nVal      (nVal),
    .dVal      (dVal)
  );
endmodule

// File: tb/clk_root_cfg_tb_top.sv
module clk_root_cfg_tb_top;
  localparam int DIV_W = 5;
  localparam int MND_W = 8;
  localparam int TMO   = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] busAddr = '0;
  logic busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic applyAck = 1'b0;
  logic [2:0] srcSel;
  logic [DIV_W-1:0] divVal;
  logic [1:0] modeVal;
  logic dualEdge;
  logic [MND_W-1:0] mVal, nVal, dVal;
  logic rootEn;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  clk_root_cfg #(.DIV_W(DIV_W), .MND_W(MND_W), .TIMEOUT_CYC(TMO)) dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .applyAck(applyAck),
    .srcSel(srcSel), .divVal(divVal), .modeVal(modeVal), .dualEdge(dualEdge),
    .mVal(mVal), .nVal(nVal), .dVal(dVal), .rootEn(rootEn)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdData;
  endtask

  task automatic ackPulse();
    @(negedge clk);
    applyAck = 1'b1;
    @(negedge clk);
    applyAck = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(3'd0, v); chk("R1 cmd", v, 32'h8000_0000);
    rd(3'd1, v); chk("R1 cfg", v, 0);
    rd(3'd2, v); chk("R1 M", v, 0);
    rd(3'd3, v); chk("R1 N", v, 0);
    rd(3'd4, v); chk("R1 D", v, 0);
    chk("R1 outputs", {divVal, srcSel, modeVal, mVal, nVal, dVal, rootEn}, 0);
  endtask

  task automatic t_shadow();
    logic [31:0] v;
    wr(3'd1, 32'hFFFF_2BE7);
    rd(3'd1, v); chk("R8 cfg field layout", v, 32'h0000_2307);
    rd(3'd0, v); chk("R3 cfg dirty bit4", v, 32'h8000_0010);
    wr(3'd2, 32'h11); wr(3'd3, 32'hEE); wr(3'd4, 32'hDD);
    rd(3'd2, v); chk("R2 M readback", v, 32'h11);
    rd(3'd3, v); chk("R2 N readback", v, 32'hEE);
    rd(3'd4, v); chk("R2 D readback", v, 32'hDD);
    rd(3'd0, v); chk("R3 all dirty bits", v, 32'h8000_00F0);
    chk("R2 outputs unchanged", {divVal, srcSel, modeVal, mVal, nVal, dVal}, 0);
  endtask

  task automatic t_updateAck();
    logic [31:0] v;
    wr(3'd0, 32'h1);
    rd(3'd0, v); chk("R4 update pending", v, 32'h8000_00F1);
    wr(3'd0, 32'h0);
    rd(3'd0, v); chk("R4 zero does not cancel", v, 32'h8000_00F1);
    chk("R2 no load before ack", {24'd0, divVal}, 0);
    ackPulse();
    chk("R5 div", {27'd0, divVal}, 7);
    chk("R5 src", {29'd0, srcSel}, 3);
    chk("R8 dualEdge for mode 2", {30'd0, modeVal, dualEdge}, 32'h5);
    chk("R5 M N D", {8'd0, mVal, nVal, dVal}, 32'h0011_EEDD);
    rd(3'd0, v); chk("R5 update and dirty cleared", v, 32'h8000_0000);
  endtask

  task automatic t_ackIdle();
    logic [31:0] v;
    wr(3'd1, 32'h0000_0105);
    ackPulse();
    chk("R6 idle ack no load", {divVal, srcSel, modeVal}, {5'd7, 3'd3, 2'd2});
    rd(3'd0, v); chk("R6 dirty kept", v, 32'h8000_0010);
  endtask

  task automatic t_root();
    logic [31:0] v;
    wr(3'd0, 32'hFFFF_FF02);
    chk("R9 rootEn follows bit1", {31'd0, rootEn}, 1);
    rd(3'd0, v); chk("R10 bit31 and dirty writes ignored", v, 32'h8000_0012);
    ackPulse();
    rd(3'd0, v); chk("R9 root-off cleared at ack", v, 32'h0000_0012);
    chk("R6 idle ack keeps outputs", {27'd0, divVal}, 7);
    wr(3'd0, 32'h0);
    chk("R9 rootEn off", {31'd0, rootEn}, 0);
    rd(3'd0, v); chk("R9 root-off holds without ack", v, 32'h0000_0010);
    ackPulse();
    rd(3'd0, v); chk("R9 root-off set at ack", v, 32'h8000_0010);
  endtask

  task automatic t_timeout();
    logic [31:0] v;
    wr(3'd0, 32'h1);
    repeat (TMO - 1) @(negedge clk);
    rd(3'd0, v); chk("R7 still pending before timeout", v, 32'h8000_0011);
    chk("R7 no load before timeout", {27'd0, divVal}, 7);
    @(negedge clk);
    rd(3'd0, v); chk("R7 cleared at timeout", v, 32'h8000_0000);
    chk("R7 forced load", {divVal, srcSel, modeVal, dualEdge}, {5'd5, 3'd1, 2'd0, 1'b0});
  endtask

  task automatic t_collide();
    logic [31:0] v;
    wr(3'd0, 32'h1);
    @(negedge clk);
    busAddr = 3'd1; busWrData = 32'h0000_0209; busWrEn = 1'b1; applyAck = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; applyAck = 1'b0;
    chk("R11 load uses older shadow", {divVal, srcSel}, {5'd5, 3'd1});
    rd(3'd0, v); chk("R11 dirty stays, update clear", v, 32'h8000_0010);
    rd(3'd1, v); chk("R11 new shadow kept", v, 32'h0000_0209);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_shadow();
    t_updateAck();
    t_ackIdle();
    t_root();
    t_timeout();
    t_collide();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule